// File: doc/BRIEF.md
# Constant-Off-Time Buck Gate Sequencer

This block drives the two gate-enable outputs of a synchronous step-down charger power stage from a fast system clock. Its inputs are comparator results that have already been digitized. It runs a peak-current cycle in four steps. A dead period comes first. The high-side switch then stays on until the sensed current crosses the control level. The low side then conducts for a programmed off period. A new cycle follows if the start conditions allow it. The switching rate is therefore close to fixed without being set by a clock divider.

The off-period length is a cycle count supplied on an input bus. The block samples it at the moment the high side turns off. That count is clamped to a minimum floor, and the floor alone is used when the stage is close to dropout. Protective flags (peak limit, overvoltage, control level below minimum) end or block conduction. A zero-crossing flag releases the low side early, which gives discontinuous operation. A global enable shuts both gates off at once.

Top module: `buck_pwm_seq`

## Requirements
- R1: A high-side pulse begins only if, in the clock cycle before it, `en` and `lvl_ok` were high and `ilim` and `ovp` were low. While `ilim` or `ovp` is held high, no pulse starts.
- R2: If `cur_hi`, `ilim` or `ovp` is high during a high-side cycle, `hs_gate` is low from the next cycle on. With `cur_hi` held high, each high-side pulse lasts exactly 1 cycle.
- R3: After a high-side pulse, `ls_gate` is high for exactly `toff_len` cycles. The length is sampled when the high side turns off.
- R4: The low-side period never lasts less than MIN_OFF cycles (60 by default). A `toff_len` below MIN_OFF is raised to MIN_OFF. While `near_drop` is high, the period is exactly MIN_OFF.
- R5: Between the end of a low-side period and the next high-side pulse, both gates stay low for exactly DEAD_CYC cycles (10 by default). The two gates are never high together.
- R6: A `zero_x` flag seen during the low-side period drops `ls_gate` in the next cycle. Both gates then stay low until the programmed off period has elapsed and the dead period has passed. A run with `cur_hi` and `zero_x` held high repeats every 1 + `toff_len` + DEAD_CYC cycles.
- R7: When `lvl_ok` is low, both gates are low from the next cycle on and the sequencer returns to idle.
- R8: When `ovp` is high, both gates are low from the next cycle on and stay low for as long as `ovp` remains high.
- R9: When `en` is low, both gates are low in the same cycle, with no clock edge needed.
- R10: A high-side pulse that no flag terminates ends after MAX_ON cycles (400 by default). A low-side period follows.
- R11: During reset, and after reset until a cycle is started, both gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Global enable; low forces both gates off at once |
| lvl_ok | input | 1 | Control level above the minimum threshold |
| cur_hi | input | 1 | Sensed current above the control level |
| ilim | input | 1 | Peak current limit reached |
| ovp | input | 1 | Output overvoltage |
| zero_x | input | 1 | Inductor current near zero |
| near_drop | input | 1 | Stage close to dropout; forces the minimum off period |
| toff_len | input | TOFF_W | Off-period length in clock cycles |
| hs_gate | output | 1 | High-side switch enable |
| ls_gate | output | 1 | Low-side switch enable |

## Verification
The bench measures the length of every gate pulse and compares it with the expected value. Four kinds of fault would show up as wrong lengths. A floor clamp that was skipped or used an inverted compare would give a 20-cycle or 150-cycle low-side pulse in place of 60. A timer off by one would shift every pulse length and the 91-cycle and 111-cycle periods. A zero-crossing handler that jumped straight to the next cycle would shorten the period. One that ignored the flag would give a 100-cycle low-side pulse in place of 1.

Flags raised in the middle of a pulse must cut it at a known cycle count and keep both gates quiet afterwards. A design that lets `ilim` or `ovp` start a cycle would produce pulses the scoreboard never expected. A design that registered the enable would show a high side still on just after `en` falls.

// File: rtl/buck_pwm_pkg.sv
package buck_pwm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEAD = 3'd1,
    ST_ON   = 3'd2,
    ST_OFF  = 3'd3,
    ST_OFFZ = 3'd4
  } pwm_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] remain,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign remain = cnt_q;
  assign last   = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/pwm_off_sel.sv
module pwm_off_sel #(
  parameter int TOFF_W  = 8,
  parameter int CNT_W   = 9,
  parameter int MIN_OFF = 60
) (
  input  logic [TOFF_W-1:0] toff_in,
  input  logic              near_drop,
  output logic [CNT_W-1:0]  off_len
);

  localparam logic [CNT_W-1:0] FLOOR_V = CNT_W'(MIN_OFF);

  logic [CNT_W-1:0] req_v;
  logic [CNT_W-1:0] clamp_v;

  assign req_v = CNT_W'(toff_in);

  generate
    if (MIN_OFF <= 1) begin : g_no_floor
      assign clamp_v = (req_v == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : req_v;
    end else begin : g_floor
      assign clamp_v = (req_v < FLOOR_V) ? FLOOR_V : req_v;
    end
  endgenerate

  assign off_len = near_drop ? FLOOR_V : clamp_v;

endmodule

// File: rtl/pwm_seq_fsm.sv
module pwm_seq_fsm
  import buck_pwm_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int DEAD_CYC = 10,
  parameter int MAX_ON   = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             lvl_ok,
  input  logic             cur_hi,
  input  logic             ilim,
  input  logic             ovp,
  input  logic             zero_x,
  input  logic             tmr_last,
  input  logic [CNT_W-1:0] off_len,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             hs_q,
  output logic             ls_q
);

  localparam logic [CNT_W-1:0] DEAD_V  = CNT_W'(DEAD_CYC);
  localparam logic [CNT_W-1:0] MAXON_V = CNT_W'(MAX_ON);

  pwm_st_e st_q, st_d;
  logic    run_ok;
  logic    st_en;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    run_ok   = en & lvl_ok & ~ovp;
    if (!run_ok) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (!ilim) begin
            st_d     = ST_DEAD;
            tmr_load = 1'b1;
            tmr_val  = DEAD_V;
          end
        end
        ST_DEAD: begin
          if (ilim) begin
            st_d = ST_IDLE;
          end else if (tmr_last) begin
            st_d     = ST_ON;
            tmr_load = 1'b1;
            tmr_val  = MAXON_V;
          end
        end
        ST_ON: begin
          if (cur_hi | ilim | tmr_last) begin
            st_d     = ST_OFF;
            tmr_load = 1'b1;
            tmr_val  = off_len;
          end
        end
        ST_OFF, ST_OFFZ: begin
          if (tmr_last) begin
            if (ilim) begin
              st_d = ST_IDLE;
            end else begin
              st_d     = ST_DEAD;
              tmr_load = 1'b1;
              tmr_val  = DEAD_V;
            end
          end else if (st_q == ST_OFF && zero_x) begin
            st_d = ST_OFFZ;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else if (st_en) begin
      st_q <= st_d;
      hs_q <= (st_d == ST_ON);
      ls_q <= (st_d == ST_OFF);
    end
  end

  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> $past(en && lvl_ok && !ilim && !ovp)); // R1

  AST_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_q && (cur_hi || ilim || ovp)) |=> !hs_q); // R2

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_q) |=> !hs_q); // R5

  AST_LVL_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_ok |=> (!hs_q && !ls_q)); // R7

  AST_OVP_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    ovp |=> (!hs_q && !ls_q)); // R8

endmodule

// File: rtl/buck_pwm_seq.sv
module buck_pwm_seq
  import buck_pwm_pkg::*;
#(
  parameter int TOFF_W   = 8,
  parameter int MIN_OFF  = 60,
  parameter int DEAD_CYC = 10,
  parameter int MAX_ON   = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              lvl_ok,
  input  logic              cur_hi,
  input  logic              ilim,
  input  logic              ovp,
  input  logic              zero_x,
  input  logic              near_drop,
  input  logic [TOFF_W-1:0] toff_len,
  output logic              hs_gate,
  output logic              ls_gate
);

  localparam int CNT_W = max2(max2($clog2(MAX_ON + 1), $clog2(DEAD_CYC + 1)),
                              max2(TOFF_W, $clog2(MIN_OFF + 1)));

  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] remain;
  logic             tmr_last;
  logic [CNT_W-1:0] off_len;
  logic             hs_q, ls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  pwm_off_sel #(
    .TOFF_W (TOFF_W),
    .CNT_W  (CNT_W),
    .MIN_OFF(MIN_OFF)
  ) u_off_sel (
    .toff_in  (toff_len),
    .near_drop(near_drop),
    .off_len  (off_len)
  );

  pwm_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .remain  (remain),
    .last    (tmr_last)
  );

  pwm_seq_fsm #(
    .CNT_W   (CNT_W),
    .DEAD_CYC(DEAD_CYC),
    .MAX_ON  (MAX_ON)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (en),
    .lvl_ok  (lvl_ok),
    .cur_hi  (cur_hi),
    .ilim    (ilim),
    .ovp     (ovp),
    .zero_x  (zero_x),
    .tmr_last(tmr_last),
    .off_len (off_len),
    .tmr_load(tmr_load),
    .tmr_val (tmr_val),
    .hs_q    (hs_q),
    .ls_q    (ls_q)
  );

  assign hs_gate = hs_q & en;
  assign ls_gate = ls_q & en;

  AST_OFF_FLOOR: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ls_q) |-> (remain >= CNT_W'(MIN_OFF))); // R4

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(hs_q) |-> $past(!ls_q)); // R5

endmodule

// File: tb/buck_pwm_seq_tb.sv
module buck_pwm_seq_tb;

  localparam int TOFF_W = 8, MIN_OFF = 60, DEAD_CYC = 10, MAX_ON = 400;

  logic clk = 1'b0;
  logic rst_n, en, lvl_ok, cur_hi, ilim, ovp, zero_x, near_drop;
  logic [TOFF_W-1:0] toff;
  logic hs, ls;

  always #2.5 clk = ~clk;

  buck_pwm_seq #(
    .TOFF_W(TOFF_W), .MIN_OFF(MIN_OFF), .DEAD_CYC(DEAD_CYC), .MAX_ON(MAX_ON)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .lvl_ok(lvl_ok), .cur_hi(cur_hi),
    .ilim(ilim), .ovp(ovp), .zero_x(zero_x), .near_drop(near_drop),
    .toff_len(toff), .hs_gate(hs), .ls_gate(ls)
  );

  typedef struct { bit is_hs; int len; string req; } pulse_t;
  pulse_t exp_q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  int hs_run = 0, ls_run = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(input bit h, input int l, input string r);
    pulse_t p;
    p.is_hs = h; p.len = l; p.req = r;
    exp_q.push_back(p);
  endtask

  task automatic score(input bit h, input int l);
    pulse_t p;
    if (exp_q.size() == 0) begin
      check(1'b0, "R1", h ? "unexpected hs pulse" : "unexpected ls pulse", l, 0);
    end else begin
      p = exp_q.pop_front();
      check(p.is_hs == h && p.len == l, p.req,
            h ? "hs pulse length" : "ls pulse length", l, p.len);
    end
  endtask

  // monitor: measures pulse lengths at the falling edge and scores them
  always @(negedge clk) begin
    if (rst_n) begin
      if (hs) hs_run++;
      else if (hs_run > 0) begin score(1'b1, hs_run); hs_run = 0; end
      if (ls) ls_run++;
      else if (ls_run > 0) begin score(1'b0, ls_run); ls_run = 0; end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  task automatic wait_drain();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #1;
      if (exp_q.size() == 0) return;
    end
    check(1'b0, "R3", "scoreboard not drained", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic park();
    lvl_ok = 1'b0;
    repeat (3) @(negedge clk);
    cur_hi = 1'b0; ilim = 1'b0; ovp = 1'b0; zero_x = 1'b0; near_drop = 1'b0;
  endtask

  task automatic wait_hs_rise();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (hs) return;
    end
  endtask

  task automatic wait_ls_rise();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ls) return;
    end
  endtask

  task automatic measure_period(output int p);
    p = 0;
    wait_hs_rise();
    do begin @(negedge clk); p++; end while (hs);
    do begin @(negedge clk); p++; end while (!hs);
  endtask

  task automatic quiet_for(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hs || ls) seen++;
    end
  endtask

  int per, seen;

  initial begin
    rst_n = 1'b0; en = 1'b1; lvl_ok = 1'b0; cur_hi = 1'b0; ilim = 1'b0;
    ovp = 1'b0; zero_x = 1'b0; near_drop = 1'b0; toff = 8'd100;
    repeat (4) @(negedge clk);
    check(!hs && !ls, "R11", "gates during reset", {hs, ls}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!hs && !ls, "R11", "gates after reset", {hs, ls}, 0);

    // R10 / R3: unterminated on-time, off period from toff
    toff = 8'd100; cur_hi = 1'b0;
    push(1'b1, MAX_ON, "R10"); push(1'b0, 100, "R3");
    push(1'b1, MAX_ON, "R10"); push(1'b0, 100, "R3");
    lvl_ok = 1'b1;
    wait_drain(); park();

    // R2 / R5: current comparator terminates, period 1 + 80 + dead
    toff = 8'd80; cur_hi = 1'b1;
    push(1'b1, 1, "R2"); push(1'b0, 80, "R3");
    push(1'b1, 1, "R2"); push(1'b0, 80, "R3");
    lvl_ok = 1'b1;
    measure_period(per);
    check(per == 1 + 80 + DEAD_CYC, "R5", "switching period", per, 1 + 80 + DEAD_CYC);
    wait_drain(); park();

    // R4: requested off below floor
    toff = 8'd20; cur_hi = 1'b1;
    push(1'b1, 1, "R2"); push(1'b0, MIN_OFF, "R4");
    lvl_ok = 1'b1;
    wait_drain(); park();

    // R4: near dropout forces floor
    toff = 8'd150; cur_hi = 1'b1; near_drop = 1'b1;
    push(1'b1, 1, "R2"); push(1'b0, MIN_OFF, "R4");
    lvl_ok = 1'b1;
    wait_drain(); park();

    // R6: zero crossing releases low side, period unchanged
    toff = 8'd100; cur_hi = 1'b1; zero_x = 1'b1;
    push(1'b1, 1, "R2"); push(1'b0, 1, "R6");
    push(1'b1, 1, "R2"); push(1'b0, 1, "R6");
    lvl_ok = 1'b1;
    measure_period(per);
    check(per == 1 + 100 + DEAD_CYC, "R6", "period with zero crossing", per, 1 + 100 + DEAD_CYC);
    wait_drain(); park();

    // R1: peak limit and overvoltage block a start
    ilim = 1'b1; lvl_ok = 1'b1;
    quiet_for(40, seen);
    check(seen == 0, "R1", "active cycles under ilim", seen, 0);
    ilim = 1'b0; ovp = 1'b1;
    quiet_for(40, seen);
    check(seen == 0, "R1", "active cycles under ovp at start", seen, 0);
    toff = 8'd70; cur_hi = 1'b1;
    push(1'b1, 1, "R1"); push(1'b0, 70, "R1");
    ovp = 1'b0;
    wait_drain(); park();

    // R8: overvoltage in the middle of the on-time
    toff = 8'd100; cur_hi = 1'b0;
    push(1'b1, 5, "R8");
    lvl_ok = 1'b1;
    wait_hs_rise();
    repeat (4) @(negedge clk);
    ovp = 1'b1;
    quiet_for(30, seen);
    check(seen == 0, "R8", "active cycles while ovp held", seen, 0);
    push(1'b1, MAX_ON, "R8"); push(1'b0, 100, "R8");
    ovp = 1'b0;
    wait_drain(); park();

    // R7: control level drops during the off period
    toff = 8'd100; cur_hi = 1'b1;
    push(1'b1, 1, "R2"); push(1'b0, 4, "R7");
    lvl_ok = 1'b1;
    wait_ls_rise();
    repeat (3) @(negedge clk);
    lvl_ok = 1'b0;
    quiet_for(20, seen);
    check(seen == 0, "R7", "active cycles with level low", seen, 0);
    park();

    // R9: enable drop cuts the high side without a clock edge
    toff = 8'd100; cur_hi = 1'b0;
    push(1'b1, 3, "R9");
    lvl_ok = 1'b1;
    wait_hs_rise();
    repeat (2) @(negedge clk);
    #1 en = 1'b0;
    #0.5 check(!hs, "R9", "hs right after enable drop", hs, 0);
    lvl_ok = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
    quiet_for(8, seen);
    check(seen == 0, "R9", "active cycles after re-enable while parked", seen, 0);
    check(exp_q.size() == 0, "R9", "pending expected pulses", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule